// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of up to sixteen transfers with no help from the host processor. The host fills three small memories: a command byte for each entry, a transmit word for each entry, and a receive word for each entry, which the controller writes back. The host then programs a first-entry and a last-entry pointer, the clock settings and the delays, and sets the enable bit.

The controller then walks the queue. For each entry it drives four peripheral chip-select lines with the values from the command byte, shifts the transmit word out on `mosi` while capturing `miso`, and stores the received bits. After the last entry it raises a done flag and can raise an interrupt. It then either stops and clears its enable bit, or it starts the queue again at the first entry when wrapping is on. A status field always holds the index of the most recently finished entry. This lets the host tell which receive words are valid while the queue is still running.

The host side is a single-cycle word bus. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `qspi_master`

## Requirements
- R1: Byte address bits [6:5] select the region: 0 receive memory, 1 transmit memory, 2 command memory, 3 registers; bits [4:1] pick the entry or register. The registers are: 0x60 control (bit0 enable, bit1 clock polarity, bit2 clock phase, bit3 wrap, bit4 interrupt enable, bits[11:8] inactive chip-select level, reset 0x0F00); 0x62 half-period divider (reset 2); 0x64 bit count (reset 8); 0x66 delays (bits[7:0] lead, bits[15:8] trail); 0x68 pointers (bits[3:0] first, bits[11:8] last); 0x6A status (bits[3:0] last finished entry, bit8 done). Host writes to the receive region have no effect.
- R2: Command byte fields: bit7 hold-select, bit6 use-bit-count, bit5 trail-delay, bit4 lead-delay, bits[3:0] chip-select values, which drive `pcs` unchanged for the whole transfer.
- R3: Once enabled, the controller runs the entries from the first pointer to the last pointer inclusive, with the index stepping modulo 16. After each entry the status field shows that entry's index.
- R4: The controller never changes the transmit or command memories.
- R5: Receive words are right-justified, and every bit above the transfer length reads zero once the entry is finished.
- R6: A transfer is 8 bits when use-bit-count is 0. When it is 1, the length is the bit-count register, clamped to the range 8..16.
- R7: `sck` rests at the clock-polarity level. It toggles every divider clock cycles and makes exactly two edges per transfer bit. With phase 0 data is captured on the leading edge; with phase 1 it is captured on the trailing edge.
- R8: The first `sck` edge comes lead+divider cycles after the chip selects change when lead-delay is 1, and 2·divider cycles after when it is 0.
- R9: The chip selects are released trail+1 cycles after the last `sck` edge when trail-delay is 1, and 2 cycles after when it is 0.
- R10: With hold-select 0 the chip selects return to the inactive level between entries. With hold-select 1 they keep the entry's values into the next entry.
- R11: After the last entry the done bit sets. Without wrapping, the enable bit clears and the controller halts. Writing 1 to status bit8 clears done. `irq` is high exactly when done and interrupt enable are both 1.
- R12: With wrap on, the queue restarts at the first pointer after the last entry and repeats until the host clears enable, which stops it at the end of the current pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 7 | Host byte address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Peripheral chip selects |
| irq | output | 1 | Queue-finished interrupt |

## Verification
The bench loops `mosi` back to `miso` and runs queues under every phase and polarity setting, at 8, 12 and clamped 16 bits. A wrong shift alignment would show up as received words that do not match the masked transmit words, or as stray upper bits. It measures the gap from chip-select change to the first clock edge and from the last edge to release, with and without the programmable delays, so a controller that miscounts a delay by one cycle is caught. It also counts chip-select releases with and without hold-select, and checks a wrapping queue that crosses index 15 to 0. That catches a controller that releases the selects too eagerly, skips entries at the wrap point, or runs past the last pointer.

// File: rtl/qspi_master.sv
module qspi_master #(
  parameter int DW      = 16,
  parameter int ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [6:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic [3:0]    pcs,
  output logic          irq
);
  localparam int AW = $clog2(ENTRIES);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LEAD, S_SHIFT, S_STORE, S_TRAIL} st_t;

  logic [DW-1:0] rx_mem [ENTRIES];
  logic [DW-1:0] tx_mem [ENTRIES];
  logic [7:0]    cmd_mem[ENTRIES];

  logic en, cpol, cpha, wrap, ie, done;
  logic [3:0] cs_idle, pcs_q;
  logic [7:0] div, lead, trail, cnt;
  logic [BW-1:0] bits, nb;
  logic [AW-1:0] qstart, qend, cur, cptqp;
  st_t st;
  logic [7:0] cmd_q;
  logic [DW-1:0] tx_sr, rx_sr;
  logic [BW:0] edg;
  logic ph;

  wire [1:0]    region = bus_addr[6:5];
  wire [AW-1:0] idx    = bus_addr[AW:1];
  wire [7:0]    cmd_cur = cmd_mem[cur];
  wire [7:0]    div_e  = (div == 8'd0) ? 8'd1 : div;
  wire [BW-1:0] bits_cl = (bits < BW'(8)) ? BW'(8) : (bits > BW'(DW)) ? BW'(DW) : bits;
  wire [BW-1:0] nb_sel = cmd_cur[6] ? bits_cl : BW'(8);
  wire [7:0] lead_len  = cmd_q[4] ? ((lead == 8'd0) ? 8'd1 : lead) : div_e;
  wire [7:0] trail_len = cmd_q[5] ? ((trail == 8'd0) ? 8'd1 : trail) : 8'd1;
  wire tick      = (cnt == div_e - 8'd1);
  wire smp       = (edg[0] == cpha);
  wire last_edge = (edg == ({nb, 1'b0} - {{BW{1'b0}}, 1'b1}));
  wire at_end    = (cur == qend);
  wire again     = wrap & en;

  assign sck  = cpol ^ ph;
  assign mosi = tx_sr[DW-1];
  assign pcs  = pcs_q;
  assign irq  = done & ie;

  always_ff @(posedge clk)
    if (bus_wr && region == 2'd1) tx_mem[idx] <= bus_wdata;

  always_ff @(posedge clk)
    if (bus_wr && region == 2'd2) cmd_mem[idx] <= bus_wdata[7:0];

  always_comb begin
    bus_rdata = '0;
    case (region)
      2'd0: bus_rdata = rx_mem[idx];
      2'd1: bus_rdata = tx_mem[idx];
      2'd2: bus_rdata = DW'(cmd_mem[idx]);
      default:
        case (idx)
          AW'(0): bus_rdata = DW'({cs_idle, 3'b000, ie, wrap, cpha, cpol, en});
          AW'(1): bus_rdata = DW'(div);
          AW'(2): bus_rdata = DW'(bits);
          AW'(3): bus_rdata = DW'({trail, lead});
          AW'(4): bus_rdata = (DW'(qend) << 8) | DW'(qstart);
          AW'(5): bus_rdata = (DW'(done) << 8) | DW'(cptqp);
          default: bus_rdata = '0;
        endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rx_mem[i] <= '0;
      {en, cpol, cpha, wrap, ie, done} <= '0;
      cs_idle <= 4'hF;  pcs_q <= 4'hF;
      div <= 8'd2;  bits <= BW'(8);  lead <= '0;  trail <= '0;
      qstart <= '0;  qend <= '0;  cur <= '0;  cptqp <= '0;
      st <= S_IDLE;  cmd_q <= '0;  nb <= BW'(8);
      tx_sr <= '0;  rx_sr <= '0;  cnt <= '0;  edg <= '0;  ph <= 1'b0;
    end else begin
      if (bus_wr && region == 2'd3)
        case (idx)
          AW'(0): begin
            {ie, wrap, cpha, cpol, en} <= bus_wdata[4:0];
            cs_idle <= bus_wdata[11:8];
          end
          AW'(1): div  <= bus_wdata[7:0];
          AW'(2): bits <= bus_wdata[BW-1:0];
          AW'(3): {trail, lead} <= bus_wdata[15:0];
          AW'(4): begin qstart <= bus_wdata[AW-1:0]; qend <= bus_wdata[8 +: AW]; end
          AW'(5): if (bus_wdata[8]) done <= 1'b0;
          default: ;
        endcase
      case (st)
        S_IDLE: begin
          ph <= 1'b0;
          if (en) begin cur <= qstart; st <= S_LOAD; end
        end
        S_LOAD: begin
          cmd_q <= cmd_cur;
          nb    <= nb_sel;
          tx_sr <= tx_mem[cur] << (DW - int'(nb_sel));
          rx_sr <= '0;
          pcs_q <= cmd_cur[3:0];
          cnt   <= '0;
          st    <= S_LEAD;
        end
        S_LEAD:
          if (cnt == lead_len - 8'd1) begin
            cnt <= '0; edg <= '0; st <= S_SHIFT;
          end else cnt <= cnt + 8'd1;
        S_SHIFT:
          if (tick) begin
            cnt <= '0;
            ph  <= ~ph;
            edg <= edg + 1'b1;
            if (smp) rx_sr <= {rx_sr[DW-2:0], miso};
            else if (edg != '0) tx_sr <= tx_sr << 1;
            if (last_edge) st <= S_STORE;
          end else cnt <= cnt + 8'd1;
        S_STORE: begin
          rx_mem[cur] <= rx_sr;
          cptqp <= cur;
          cnt <= '0;
          st <= S_TRAIL;
        end
        S_TRAIL:
          if (cnt == trail_len - 8'd1) begin
            cnt <= '0;
            if (!cmd_q[7] || (at_end && !again)) pcs_q <= cs_idle;
            if (at_end) begin
              done <= 1'b1;
              if (again) begin cur <= qstart; st <= S_LOAD; end
              else begin en <= 1'b0; st <= S_IDLE; end
            end else begin
              cur <= cur + 1'b1;
              st <= S_LOAD;
            end
          end else cnt <= cnt + 8'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_sck_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SHIFT) |-> (sck == cpol));
  a_r2_pcs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> $stable(pcs));
  a_r6_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> (edg < {nb, 1'b0}));
  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cptqp == qend));
endmodule

// File: tb/tb_qspi_master.sv
`timescale 1ns/1ps
module tb_qspi_master;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso;
  logic [3:0] pcs;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign miso = mosi;

  qspi_master dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .pcs(pcs), .irq(irq));

  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0] pcs_p = 4'hF;
  logic sck_p = 1'b0;
  bit armed = 0;
  int n_edges = 0, n_rel = 0, lead_gap = 0, trail_gap = 0, t_cs = 0, t_sck = 0;
  always @(negedge clk) begin
    if (sck !== sck_p) begin
      n_edges++; t_sck = cyc;
      if (armed) begin lead_gap = cyc - t_cs; armed = 0; end
    end
    if (pcs !== pcs_p) begin
      if (pcs == 4'hF) begin n_rel++; trail_gap = cyc - t_sck; end
      else if (pcs_p == 4'hF) begin t_cs = cyc; armed = 1; end
    end
    pcs_p = pcs; sck_p = sck;
  end

  task automatic mon_clr();
    @(negedge clk); #1;
    n_edges = 0; n_rel = 0; lead_gap = 0; trail_gap = 0; armed = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(7'h6A, s);
      if (s[8]) return;
    end
    chk(req, 0, 1);
  endtask

  task automatic entry(input int i, input logic [7:0] c, input logic [15:0] t);
    wr(7'h40 + 7'(2*i), {8'h00, c});
    wr(7'h20 + 7'(2*i), t);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 reset pcs", pcs, 4'hF);
    chk("R7 reset sck", sck, 0);
    chk("R11 reset irq", irq, 0);
    rd(7'h60, d); chk("R1 ctrl reset", d, 16'h0F00);
    rd(7'h6A, d); chk("R11 status reset", d, 0);
    rd(7'h62, d); chk("R1 divider reset", d, 2);
    rd(7'h00, d); chk("R5 rx reset", d, 0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    entry(0, 8'h0E, 16'hA5C3); entry(1, 8'h0E, 16'h1234); entry(2, 8'h0E, 16'hFFFF);
    wr(7'h68, 16'h0200); wr(7'h62, 16'd2);
    wr(7'h06, 16'hBEEF);
    mon_clr();
    wr(7'h60, 16'h0F01);
    wait_done("R11 basic done");
    rd(7'h00, d); chk("R5 rx0 8-bit", d, 16'h00C3);
    rd(7'h02, d); chk("R5 rx1 8-bit", d, 16'h0034);
    rd(7'h04, d); chk("R6 rx2 8-bit", d, 16'h00FF);
    rd(7'h06, d); chk("R1 host rx write ignored", d, 0);
    rd(7'h6A, d); chk("R3 status last entry", d, 16'h0102);
    rd(7'h20, d); chk("R4 tx kept", d, 16'hA5C3);
    rd(7'h40, d); chk("R4 cmd kept", d, 16'h000E);
    rd(7'h60, d); chk("R11 enable cleared", d, 16'h0F00);
    chk("R11 irq masked", irq, 0);
    chk("R7 edge count", n_edges, 48);
    chk("R10 releases no hold", n_rel, 3);
    chk("R8 lead gap plain", lead_gap, 4);
    chk("R9 trail gap plain", trail_gap, 2);
    wr(7'h6A, 16'h0100);
  endtask

  task automatic t_bits12();
    logic [15:0] d;
    entry(3, 8'h4D, 16'hABCD); entry(4, 8'h4D, 16'h0F0F);
    wr(7'h64, 16'd12); wr(7'h62, 16'd3); wr(7'h68, 16'h0403);
    wr(7'h60, 16'h0F06);
    mon_clr();
    wr(7'h60, 16'h0F07);
    wait_done("R11 bits12 done");
    rd(7'h06, d); chk("R6 rx3 12-bit phase1", d, 16'h0BCD);
    rd(7'h08, d); chk("R5 rx4 12-bit", d, 16'h0F0F);
    rd(7'h6A, d); chk("R3 status entry 4", d, 16'h0104);
    chk("R7 edges 12-bit", n_edges, 48);
    chk("R7 sck rests high", sck, 1);
    chk("R8 lead gap div3", lead_gap, 6);
    wr(7'h6A, 16'h0100);
  endtask

  task automatic t_bits16();
    logic [15:0] d;
    entry(5, 8'h4B, 16'h8001);
    wr(7'h64, 16'd20); wr(7'h62, 16'd1); wr(7'h68, 16'h0505);
    wr(7'h60, 16'h0F04);
    mon_clr();
    wr(7'h60, 16'h0F05);
    wait_done("R11 bits16 done");
    rd(7'h0A, d); chk("R6 rx5 clamped 16", d, 16'h8001);
    chk("R6 edges clamped 16", n_edges, 32);
    chk("R7 sck rests low", sck, 0);
    wr(7'h6A, 16'h0100);
  endtask

  task automatic t_delay();
    logic [15:0] d;
    entry(6, 8'h37, 16'h005A);
    wr(7'h64, 16'd8); wr(7'h62, 16'd2); wr(7'h66, 16'h0609); wr(7'h68, 16'h0606);
    wr(7'h60, 16'h0F00);
    mon_clr();
    wr(7'h60, 16'h0F01);
    wait_done("R11 delay done");
    chk("R8 lead delay", lead_gap, 11);
    chk("R9 trail delay", trail_gap, 7);
    rd(7'h0C, d); chk("R5 rx6", d, 16'h005A);
    wr(7'h6A, 16'h0100);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    entry(7, 8'h8E, 16'h0011); entry(8, 8'h8E, 16'h0022); entry(9, 8'h0E, 16'h0033);
    wr(7'h68, 16'h0907);
    mon_clr();
    wr(7'h60, 16'h0F01);
    wait_done("R11 hold done");
    chk("R10 releases with hold", n_rel, 1);
    rd(7'h10, d); chk("R10 rx8 data", d, 16'h0022);
    chk("R2 pcs idle after queue", pcs, 4'hF);
    wr(7'h6A, 16'h0100);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(7'h68, 16'h0000);
    wr(7'h60, 16'h0F11);
    wait_done("R11 irq done");
    @(negedge clk); chk("R11 irq raised", irq, 1);
    wr(7'h6A, 16'h0100);
    rd(7'h6A, d); chk("R11 done cleared", d[8], 0);
    chk("R11 irq dropped", irq, 0);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    int e;
    entry(14, 8'h0E, 16'h0011); entry(15, 8'h0E, 16'h0022);
    entry(0, 8'h0E, 16'h0033); entry(1, 8'h0E, 16'h0044);
    wr(7'h68, 16'h010E);
    wr(7'h60, 16'h0F09);
    wait_done("R12 first pass");
    wr(7'h6A, 16'h0100);
    wait_done("R12 second pass");
    rd(7'h60, d); chk("R12 enable kept while wrapping", d[0], 1);
    wr(7'h60, 16'h0F08);
    repeat (800) @(negedge clk);
    mon_clr();
    repeat (500) @(negedge clk);
    e = n_edges;
    chk("R12 halted after enable cleared", e, 0);
    rd(7'h1C, d); chk("R12 rx14", d, 16'h0011);
    rd(7'h1E, d); chk("R3 rx15", d, 16'h0022);
    rd(7'h00, d); chk("R3 rx0 after wrap", d, 16'h0033);
    rd(7'h02, d); chk("R12 rx1", d, 16'h0044);
    rd(7'h04, d); chk("R3 rx2 untouched", d, 16'h00FF);
    rd(7'h6A, d); chk("R3 status last", d[3:0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bits12();
    t_bits16();
    t_delay();
    t_hold();
    t_irq();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule